// File: doc/BRIEF.md
# Bit-Serial Non-Restoring Integer Square Root

This unit takes an unsigned radicand of twice the root width and returns the floor of its square root. It works one root bit per clock. The root starts at zero and a remainder register starts at the radicand. In each pass the unit moves the root by plus or minus a power-of-two weight. The sign of the remainder decides which way: a remainder that is zero or positive adds the weight, a negative one subtracts it. A single adder/subtracter brings the remainder into line with the new root.

Shifts and ORs form the remainder correction term. No multiplier is used. The lowest set bit of the partial root always sits just above the current weight, so none of these shifted pieces overlap.

After the passes, the root is either exact or odd and one too large. A final cleanup cycle reuses the same adder to decrement the root when the remainder is negative. A request is accepted only while the unit is idle. Completion is shown by a one-cycle pulse, and the root then stays on the output until the next accepted request.

Top module: `nr_isqrt`

## Requirements
- R1: For every radicand x in 0 to 2^(2N)-1, the reported root y satisfies y*y <= x < (y+1)*(y+1), where N is the root width.
- R2: With a request accepted at clock edge E0, `doneValid` is high in exactly the cycle that follows edge E0+N+1, and `busy` is high from after E0 until that same edge.
- R3: A `startValid` raised while `busy` is high is ignored: neither the result nor the completion time of the running operation changes.
- R4: `doneValid` is high for one cycle per accepted request.
- R5: After completion, `root` keeps its value until the next request is accepted.
- R6: After reset, `busy` and `doneValid` are low and `root` is zero.
- R7: The boundary radicands give exact results: 0 gives 0, 2^(2N)-1 gives 2^N-1, and a perfect square k*k gives k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Request strobe; sampled only while idle |
| radicand | input | 2*ROOT_W | Unsigned value whose root is taken |
| busy | output | 1 | High while an operation is in progress |
| doneValid | output | 1 | One-cycle completion pulse |
| root | output | ROOT_W | Floor square root, held until the next request |

## Verification
Two configurations are tested. At a root width of 5, every radicand is applied, so each pattern of add and subtract decisions occurs, along with every non-square whose root must be pulled down in cleanup. At a root width of 12, random radicands are applied, together with perfect squares, zero and the all-ones value. These separate a correct cleanup from one that is skipped or always applied, and show whether the sign test treats a zero remainder correctly. Requests raised during an operation check the idle-only acceptance, and the timing checks around the completion pulse cover the latency and the holding of the result.

// File: rtl/nr_sqrt_pkg.sv
package nr_sqrt_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture radicand, clear root
    logic step;   // one non-restoring pass
    logic fix;    // final cleanup cycle
  } sqrtCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } sqrtState_e;

endpackage

// File: rtl/nr_sqrt_addsub.sv
module nr_sqrt_addsub #(
  parameter int WIDTH = 18
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             sub,
  output logic [WIDTH-1:0] sum
);

  logic [WIDTH-1:0] opBx;

  always_comb begin
    opBx = sub ? ~opB : opB;
    sum  = opA + opBx + WIDTH'(sub);
  end

endmodule

// File: rtl/nr_sqrt_ctrl.sv
module nr_sqrt_ctrl
  import nr_sqrt_pkg::*;
#(
  parameter int ROOT_W = 8,
  localparam int IDX_W = $clog2(ROOT_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  output sqrtCtl_t         ctl,
  output logic [IDX_W-1:0] stepIdx,
  output logic             busy,
  output logic             doneValid
);

  localparam int CNT_W = IDX_W + 2;

  sqrtState_e state;
  logic       lastStep;

  always_comb begin
    lastStep = (stepIdx == '0);
    ctl.load = startValid && (state == ST_IDLE);
    ctl.step = (state == ST_ITER);
    ctl.fix  = (state == ST_FIX);
    busy     = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepIdx   <= '0;
      doneValid <= 1'b0;
    end else begin
      doneValid <= ctl.fix;
      unique case (state)
        ST_IDLE: if (ctl.load) begin
          state   <= ST_ITER;
          stepIdx <= IDX_W'(ROOT_W - 1);
        end
        ST_ITER: begin
          if (lastStep) state <= ST_FIX;
          else          stepIdx <= stepIdx - 1'b1;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker state: cycles spent busy since the last accepted request
  logic [CNT_W-1:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busyCnt <= '0;
    else if (ctl.load)  busyCnt <= '0;
    else if (busy)      busyCnt <= busyCnt + 1'b1;
  end

  // R2: completion comes N+1 busy cycles after acceptance
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (busyCnt == CNT_W'(ROOT_W + 1)));

  // R4: completion is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R3: a request during iteration does not end the running operation
  p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ITER && startValid) |=> busy);

  // R2: at most one strobe per cycle
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.step, ctl.fix}));

endmodule

// File: rtl/nr_sqrt_datapath.sv
module nr_sqrt_datapath
  import nr_sqrt_pkg::*;
#(
  parameter int ROOT_W = 8,
  localparam int IDX_W = $clog2(ROOT_W),
  localparam int RAD_W = 2 * ROOT_W,
  localparam int REM_W = RAD_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  sqrtCtl_t          ctl,
  input  logic [IDX_W-1:0]  stepIdx,
  input  logic [RAD_W-1:0]  radicand,
  output logic [ROOT_W-1:0] root
);

  logic [REM_W-1:0]  remReg;
  logic [ROOT_W-1:0] rootReg;
  logic              remNeg;
  logic [ROOT_W-1:0] setBit;
  logic [ROOT_W-1:0] rootNext;
  logic [ROOT_W-1:0] termBase;
  logic [IDX_W:0]    shAmt;
  logic [IDX_W:0]    sqAmt;
  logic [REM_W-1:0]  term;
  logic [REM_W-1:0]  opA;
  logic [REM_W-1:0]  opB;
  logic              doSub;
  logic [REM_W-1:0]  sum;

  always_comb begin
    remNeg = remReg[REM_W-1];
    setBit = ROOT_W'(1) << stepIdx;
    // Lowest set bit of rootReg sits at stepIdx+1, so both moves are bit edits
    if (remNeg) rootNext = (rootReg & ~{setBit[ROOT_W-2:0], 1'b0}) | setBit;
    else        rootNext = rootReg | setBit;
    // Change of y*y is 2*base*w + w*w, base being the smaller of old/new root
    termBase = remNeg ? rootNext : rootReg;
    shAmt    = {1'b0, stepIdx} + 1'b1;
    sqAmt    = {stepIdx, 1'b0};
    term     = (REM_W'(termBase) << shAmt) | (REM_W'(1) << sqAmt);
    if (ctl.fix) begin
      opA   = REM_W'(rootReg);
      opB   = REM_W'(1);
      doSub = 1'b1;
    end else begin
      opA   = remReg;
      opB   = term;
      doSub = !remNeg;
    end
  end

  nr_sqrt_addsub #(.WIDTH(REM_W)) addsub_i (
    .opA (opA),
    .opB (opB),
    .sub (doSub),
    .sum (sum)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg  <= '0;
      rootReg <= '0;
    end else if (ctl.load) begin
      remReg  <= REM_W'(radicand);
      rootReg <= '0;
    end else if (ctl.step) begin
      remReg  <= sum;
      rootReg <= rootNext;
    end else if (ctl.fix && remNeg) begin
      rootReg <= sum[ROOT_W-1:0];
    end
  end

  assign root = rootReg;

  // R1: before cleanup the root is exact (zero remainder) or odd
  p_odd_unless_exact_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fix && remReg != '0) |-> rootReg[0]);

  // R1: an exact root keeps its value through cleanup
  p_exact_kept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fix && !remNeg) |=> $stable(rootReg));

  // R5: without a strobe the root holds
  p_root_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.load || ctl.step || ctl.fix) |=> $stable(rootReg));

endmodule

// File: rtl/nr_isqrt.sv
module nr_isqrt
  import nr_sqrt_pkg::*;
#(
  parameter int ROOT_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startValid,
  input  logic [2*ROOT_W-1:0]   radicand,
  output logic                  busy,
  output logic                  doneValid,
  output logic [ROOT_W-1:0]     root
);

  localparam int IDX_W = $clog2(ROOT_W);

  sqrtCtl_t         ctl;
  logic [IDX_W-1:0] stepIdx;

  nr_sqrt_ctrl #(.ROOT_W(ROOT_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .ctl        (ctl),
    .stepIdx    (stepIdx),
    .busy       (busy),
    .doneValid  (doneValid)
  );

  nr_sqrt_datapath #(.ROOT_W(ROOT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .stepIdx  (stepIdx),
    .radicand (radicand),
    .root     (root)
  );

endmodule

// File: tb/nr_isqrt_tb_top.sv
`timescale 1ns/1ps
module nr_isqrt_tb_top;

  localparam int NS = 5;
  localparam int NL = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          startS = 1'b0, busyS, doneS;
  logic [2*NS-1:0] radS = '0;
  logic [NS-1:0]   rootS;
  logic          startL = 1'b0, busyL, doneL;
  logic [2*NL-1:0] radL = '0;
  logic [NL-1:0]   rootL;

  nr_isqrt #(.ROOT_W(NS)) dut_i (
    .clk(clk), .rstN(rstN), .startValid(startS), .radicand(radS),
    .busy(busyS), .doneValid(doneS), .root(rootS));

  nr_isqrt #(.ROOT_W(NL)) dutBig_i (
    .clk(clk), .rstN(rstN), .startValid(startL), .radicand(radL),
    .busy(busyL), .doneValid(doneL), .root(rootL));

  int total = 0;
  int failed = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint isq(input longint x);
    longint y = 0;
    while ((y + 1) * (y + 1) <= x) y++;
    return y;
  endfunction

  // Run one operation on the small unit; poke raises a second request mid-run
  task automatic opS(input int x, input bit poke, output int r, output int lat);
    @(negedge clk); startS = 1'b1; radS = (2*NS)'(x);
    @(negedge clk); startS = 1'b0; radS = '0;
    lat = 1;
    while (!doneS && lat < 64) begin
      if (poke && lat == 3) begin startS = 1'b1; radS = '1; end
      else startS = 1'b0;
      @(negedge clk); lat++;
    end
    startS = 1'b0;
    r = int'(rootS);
  endtask

  task automatic opL(input int x, output int r, output int lat);
    @(negedge clk); startL = 1'b1; radL = (2*NL)'(x);
    @(negedge clk); startL = 1'b0;
    lat = 1;
    while (!doneL && lat < 64) begin @(negedge clk); lat++; end
    r = int'(rootL);
  endtask

  initial begin
    #(5.0 * 190000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int r, lat, hold, ex;
    repeat (3) @(negedge clk);
    // R6: reset state
    chk(busyS == 0 && doneS == 0, "R6 flags", {busyS, doneS}, 0);
    chk(rootS == 0, "R6 root", rootS, 0);
    chk(busyL == 0 && doneL == 0 && rootL == 0, "R6 big", rootL, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1, R2: exhaustive sweep of the small unit
    for (int x = 0; x < (1 << (2*NS)); x++) begin
      opS(x, 1'b0, r, lat);
      ex = int'(isq(x));
      chk(longint'(r)*r <= x && longint'(r+1)*(r+1) > x, "R1 small", r, ex);
      chk(lat == NS + 2, "R2 latency", lat, NS + 2);
    end

    // R7: boundaries
    opS(0, 1'b0, r, lat);
    chk(r == 0, "R7 zero", r, 0);
    opS((1 << (2*NS)) - 1, 1'b0, r, lat);
    chk(r == (1 << NS) - 1, "R7 max", r, (1 << NS) - 1);

    // R4, R5: pulse width and hold
    opS(700, 1'b0, r, lat);
    @(negedge clk);
    chk(doneS == 0, "R4 pulse", doneS, 0);
    chk(busyS == 0, "R2 busy low", busyS, 0);
    repeat (5) @(negedge clk);
    hold = int'(rootS);
    chk(hold == 26, "R5 hold", hold, 26);

    // R3: request while busy is ignored
    opS(50, 1'b1, r, lat);
    chk(r == 7, "R3 result", r, 7);
    chk(lat == NS + 2, "R3 latency", lat, NS + 2);
    @(negedge clk);
    chk(busyS == 0, "R3 no restart", busyS, 0);

    // R1, R7: large unit
    opL((1 << (2*NL)) - 1, r, lat);
    chk(r == (1 << NL) - 1, "R7 big max", r, (1 << NL) - 1);
    chk(lat == NL + 2, "R2 big latency", lat, NL + 2);
    for (int k = 1; k < 4096; k += 97) begin
      opL(k * k, r, lat);
      chk(r == k, "R7 square", r, k);
      opL(k * k - 1, r, lat);
      chk(r == k - 1, "R1 below square", r, k - 1);
    end
    for (int n = 0; n < 1500; n++) begin
      int x;
      x = int'($urandom() & 32'h00FF_FFFF);
      opL(x, r, lat);
      ex = int'(isq(x));
      chk(longint'(r)*r <= x && longint'(r+1)*(r+1) > x, "R1 big", r, ex);
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule